// File: doc/BRIEF.md
# Credit-Flow Flit Link Port

This block is one end of a point-to-point, full-duplex link between two nodes of a packet-switched on-chip network. Each direction carries a 36-bit flit. The flit holds a 32-bit data word, a 3-bit packet kind and one parity bit. Three side wires go with it: a valid line, an end-of-packet line, and a credit line that runs the other way. The local sender hands over data words one at a time and marks the last one. The port turns them into a packet on the wire. The first word is the header. The packet kind taken with the header goes into every flit of that packet. After the last word the port adds a closing flit of its own, which carries an XOR checksum of the packet's data words.

The sender never overruns the far buffer. It holds a count of free slots at the receiver. It spends one slot for every flit it puts on the wire and gets one back for every pulse on the incoming credit line. While that count is zero, it accepts nothing. The receiving half stores arriving flits in a buffer whose depth matches the far sender's credit count. It checks the parity of every flit and the checksum in every closing flit, and reports each failure as a one-cycle pulse. The flit is still stored and delivered. It returns one credit each time the local reader takes a flit out of the buffer.

Packet kinds are 3-bit codes. 000 and 001 are system kinds. 010 is a stream fragment and 011 is a credit message. 110 is a bus initiator and 111 is a bus target. 100 and 101 are left free for users. Payload length is unbounded.

Top module: `flit_link_port`

## Requirements
- R1: Every flit leaving the port has the parity bit at bit 35, the packet kind at bits 34:32 and the data word at bits 31:0, and the parity bit makes the XOR of all 36 bits zero.
- R2: After reset the sender holds DEPTH credits (default 4). With a receiver that never reads, exactly DEPTH flits are accepted and sent, and then `snd_ready` stays low.
- R3: The sender accepts and sends a flit only while it holds a credit. Each credit pulse restores exactly one, so after any traffic the count again allows exactly DEPTH flits into a stalled receiver.
- R4: After the flit marked `snd_last` is accepted, the next flit on the link is a closing flit. It has `lnk_o_end` high, and its data is the XOR of every data word of that packet. `snd_ready` is low in the cycle after the last word is accepted.
- R5: The first word of a packet is its header. The `snd_type` value given with the header is the kind of every flit of that packet, including the closing flit, and `snd_type` on later words is ignored.
- R6: The receiver pulses `lnk_o_crd` for one cycle, in the cycle after each flit (closing flits included) is read out through `rcv_valid`/`rcv_ready`, and at no other time.
- R7: `rcv_par_err` pulses in the cycle after a flit whose 36 bits have odd XOR enters the receiver, and that flit is still delivered unchanged.
- R8: `rcv_sum_err` pulses in the cycle after a closing flit enters whose data differs from the XOR of the data of all non-closing flits received since the previous closing flit.
- R9: Received flits reach `rcv_data`, `rcv_type` and `rcv_end` in arrival order, and none is lost or duplicated.
- R10: `lnk_o_vld` is low when no flit is sent, and `lnk_o_end` is high only together with `lnk_o_vld`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| snd_valid | input | 1 | Sender offers a data word |
| snd_ready | output | 1 | Port accepts the offered word this cycle |
| snd_data | input | 32 | Data word to send |
| snd_type | input | 3 | Packet kind, taken with the header word only |
| snd_last | input | 1 | Offered word is the last of its packet |
| lnk_o_flit | output | 36 | Outgoing flit {parity, kind, data} |
| lnk_o_vld | output | 1 | Outgoing flit is valid |
| lnk_o_end | output | 1 | Outgoing flit is a closing flit |
| lnk_o_crd | output | 1 | Credit pulse returned to the far sender |
| lnk_i_flit | input | 36 | Incoming flit {parity, kind, data} |
| lnk_i_vld | input | 1 | Incoming flit is valid |
| lnk_i_end | input | 1 | Incoming flit is a closing flit |
| lnk_i_crd | input | 1 | Credit pulse from the far receiver |
| rcv_valid | output | 1 | A received flit is available |
| rcv_ready | input | 1 | Reader takes the available flit |
| rcv_data | output | 32 | Data of the head-of-buffer flit |
| rcv_type | output | 3 | Kind of the head-of-buffer flit |
| rcv_end | output | 1 | Head-of-buffer flit is a closing flit |
| rcv_par_err | output | 1 | Parity failure pulse |
| rcv_sum_err | output | 1 | Checksum failure pulse |

## Verification
The credit counter can see a flit being sent and a credit coming back on the same clock edge. In that case it must keep its value. The bench drives this case by wiring the link back on itself and streaming packets while the reader takes flits every cycle or at random. Then every read's credit arrives while the sender keeps spending. The case is judged at the ports afterwards. The reader is stalled, and the bench counts that exactly DEPTH flits get through before `snd_ready` falls. A lost or doubled credit on a shared edge shows up as one flit too few or too many.

// File: rtl/flit_pkg.sv
package flit_pkg;

    localparam int DATA_W = 32;
    localparam int KIND_W = 3;
    localparam int FLIT_W = DATA_W + KIND_W + 1;

    typedef enum logic [KIND_W-1:0] {
        PK_SYS_CTL  = 3'b000,
        PK_SYS_RSV  = 3'b001,
        PK_STREAM   = 3'b010,
        PK_CREDIT   = 3'b011,
        PK_USER_A   = 3'b100,
        PK_USER_B   = 3'b101,
        PK_BUS_INIT = 3'b110,
        PK_BUS_TGT  = 3'b111
    } pkind_e;

    typedef struct packed {
        logic              par;
        pkind_e            kind;
        logic [DATA_W-1:0] data;
    } flit_t;

    typedef struct packed {
        logic  last;
        flit_t flit;
    } rx_entry_t;

    typedef enum logic [1:0] {
        TX_HEAD,
        TX_BODY,
        TX_TRAIL
    } tx_state_e;

    function automatic flit_t make_flit(pkind_e k, logic [DATA_W-1:0] d);
        flit_t f;
        f.kind = k;
        f.data = d;
        f.par  = ^{k, d};
        return f;
    endfunction

    function automatic logic flit_bad(flit_t f);
        return ^f;
    endfunction

endpackage

// File: rtl/credit_counter.sv
module credit_counter #(
    parameter int DEPTH = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic take,
    input  logic give,
    output logic has_credit
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= CW'(DEPTH);
        end else begin
            case ({take, give})
                2'b10:   cnt <= cnt - 1'b1;
                2'b01:   cnt <= cnt + 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    assign has_credit = (cnt != '0);

    // R3
    spend_needs_credit_chk: assert property (@(posedge clk) disable iff (rst)
        take |-> (cnt != '0));

    // R2
    credit_ceiling_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(DEPTH));

    // R3
    no_spurious_credit_chk: assert property (@(posedge clk) disable iff (rst)
        (give && !take) |-> (cnt < CW'(DEPTH)));

endmodule

// File: rtl/link_tx.sv
module link_tx
    import flit_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              snd_valid,
    output logic              snd_ready,
    input  logic [DATA_W-1:0] snd_data,
    input  logic [KIND_W-1:0] snd_type,
    input  logic              snd_last,
    input  logic              has_credit,
    output logic              take,
    output flit_t             out_flit,
    output logic              out_vld,
    output logic              out_end
);
    tx_state_e         state;
    pkind_e            pkt_kind;
    logic [DATA_W-1:0] sum;
    logic              word_hs;
    logic              trail_go;
    pkind_e            kind_now;

    assign snd_ready = has_credit && (state != TX_TRAIL);
    assign word_hs   = snd_valid && snd_ready;
    assign trail_go  = (state == TX_TRAIL) && has_credit;
    assign take      = word_hs || trail_go;
    assign kind_now  = (state == TX_HEAD) ? pkind_e'(snd_type) : pkt_kind;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= TX_HEAD;
            pkt_kind <= PK_SYS_CTL;
            sum      <= '0;
            out_flit <= '0;
            out_vld  <= 1'b0;
            out_end  <= 1'b0;
        end else begin
            out_vld <= take;
            out_end <= trail_go;
            if (word_hs) begin
                out_flit <= make_flit(kind_now, snd_data);
                sum      <= sum ^ snd_data;
                pkt_kind <= kind_now;
                state    <= snd_last ? TX_TRAIL : TX_BODY;
            end else if (trail_go) begin
                out_flit <= make_flit(pkt_kind, sum);
                sum      <= '0;
                state    <= TX_HEAD;
            end
        end
    end

    // R1
    tx_even_parity_chk: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> !flit_bad(out_flit));

    // R4
    trail_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (word_hs && snd_last) |=> !snd_ready);

    // R10
    end_with_vld_chk: assert property (@(posedge clk) disable iff (rst)
        out_end |-> out_vld);

endmodule

// File: rtl/rx_buffer.sv
module rx_buffer #(
    parameter int DEPTH = 4,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  logic [W-1:0] din,
    input  logic         rd,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;

    function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty = (cnt == '0);
    assign full  = (cnt == CW'(DEPTH));
    assign dout  = mem[rp];

    always_ff @(posedge clk) begin
        if (wr) begin
            mem[wp] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (wr) wp <= bump(wp);
            if (rd) rp <= bump(rp);
            case ({wr, rd})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        wr |-> !full);

    // R9
    no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
        rd |-> !empty);

endmodule

// File: rtl/link_rx.sv
module link_rx
    import flit_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  flit_t             in_flit,
    input  logic              in_vld,
    input  logic              in_end,
    output logic              rcv_valid,
    input  logic              rcv_ready,
    output logic [DATA_W-1:0] rcv_data,
    output logic [KIND_W-1:0] rcv_type,
    output logic              rcv_end,
    output logic              par_err,
    output logic              sum_err,
    output logic              crd_out
);
    localparam int EW = $bits(rx_entry_t);

    rx_entry_t         wr_ent, rd_ent;
    logic [EW-1:0]     rd_raw;
    logic              empty, full, rd;
    logic [DATA_W-1:0] acc;

    assign wr_ent.last = in_end;
    assign wr_ent.flit = in_flit;
    assign rd_ent      = rx_entry_t'(rd_raw);
    assign rcv_valid   = !empty;
    assign rd          = rcv_valid && rcv_ready;
    assign rcv_data    = rd_ent.flit.data;
    assign rcv_type    = rd_ent.flit.kind;
    assign rcv_end     = rd_ent.last;

    rx_buffer #(.DEPTH(DEPTH), .W(EW)) u_buf (
        .clk  (clk),
        .rst  (rst),
        .wr   (in_vld),
        .din  (EW'(wr_ent)),
        .rd   (rd),
        .dout (rd_raw),
        .empty(empty),
        .full (full)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            acc     <= '0;
            par_err <= 1'b0;
            sum_err <= 1'b0;
            crd_out <= 1'b0;
        end else begin
            crd_out <= rd;
            par_err <= in_vld && flit_bad(in_flit);
            sum_err <= in_vld && in_end && (in_flit.data != acc);
            if (in_vld) begin
                acc <= in_end ? '0 : (acc ^ in_flit.data);
            end
        end
    end

    // R7
    par_after_flit_chk: assert property (@(posedge clk) disable iff (rst)
        par_err |-> $past(in_vld));

    // R8
    sum_after_trail_chk: assert property (@(posedge clk) disable iff (rst)
        sum_err |-> ($past(in_vld) && $past(in_end)));

    // R6
    credit_after_read_chk: assert property (@(posedge clk) disable iff (rst)
        crd_out |-> $past(rcv_valid));

endmodule

// File: rtl/flit_link_port.sv
module flit_link_port
    import flit_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        snd_valid,
    output logic        snd_ready,
    input  logic [31:0] snd_data,
    input  logic [2:0]  snd_type,
    input  logic        snd_last,
    output logic [35:0] lnk_o_flit,
    output logic        lnk_o_vld,
    output logic        lnk_o_end,
    output logic        lnk_o_crd,
    input  logic [35:0] lnk_i_flit,
    input  logic        lnk_i_vld,
    input  logic        lnk_i_end,
    input  logic        lnk_i_crd,
    output logic        rcv_valid,
    input  logic        rcv_ready,
    output logic [31:0] rcv_data,
    output logic [2:0]  rcv_type,
    output logic        rcv_end,
    output logic        rcv_par_err,
    output logic        rcv_sum_err
);
    logic  has_credit;
    logic  take;
    flit_t tx_flit;

    credit_counter #(.DEPTH(DEPTH)) u_credit (
        .clk       (clk),
        .rst       (rst),
        .take      (take),
        .give      (lnk_i_crd),
        .has_credit(has_credit)
    );

    link_tx u_tx (
        .clk       (clk),
        .rst       (rst),
        .snd_valid (snd_valid),
        .snd_ready (snd_ready),
        .snd_data  (snd_data),
        .snd_type  (snd_type),
        .snd_last  (snd_last),
        .has_credit(has_credit),
        .take      (take),
        .out_flit  (tx_flit),
        .out_vld   (lnk_o_vld),
        .out_end   (lnk_o_end)
    );

    assign lnk_o_flit = FLIT_W'(tx_flit);

    link_rx #(.DEPTH(DEPTH)) u_rx (
        .clk      (clk),
        .rst      (rst),
        .in_flit  (flit_t'(lnk_i_flit)),
        .in_vld   (lnk_i_vld),
        .in_end   (lnk_i_end),
        .rcv_valid(rcv_valid),
        .rcv_ready(rcv_ready),
        .rcv_data (rcv_data),
        .rcv_type (rcv_type),
        .rcv_end  (rcv_end),
        .par_err  (rcv_par_err),
        .sum_err  (rcv_sum_err),
        .crd_out  (lnk_o_crd)
    );

endmodule

// File: tb/flit_link_port_test.sv
module flit_link_port_test;

    localparam int DEPTH = 4;

    typedef struct packed {
        logic        endf;
        logic [2:0]  kind;
        logic [31:0] data;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst;
    logic        snd_valid, snd_ready, snd_last;
    logic [31:0] snd_data;
    logic [2:0]  snd_type;
    logic [35:0] lnk_o_flit, lnk_i_flit;
    logic        lnk_o_vld, lnk_o_end, lnk_o_crd;
    logic        lnk_i_vld, lnk_i_end, lnk_i_crd;
    logic        rcv_valid, rcv_ready, rcv_end, rcv_par_err, rcv_sum_err;
    logic [31:0] rcv_data;
    logic [2:0]  rcv_type;

    int unsigned link_cnt;
    int unsigned corrupt_at = 32'hFFFF_FFFF;
    logic [35:0] corrupt_val = '0;
    int          rx_mode = 0;

    int checks = 0;
    int fails  = 0;
    int hs_cnt = 0;
    int par_seen = 0;
    int sum_seen = 0;

    exp_t        tx_q[$];
    exp_t        rx_q[$];
    logic [2:0]  pkt_kind_b = '0;
    logic [31:0] tx_sum_b = '0;
    logic [31:0] rx_acc_b = '0;
    bit          in_pkt = 0;
    bit          gap_pending = 0;
    bit          exp_par = 0, exp_sum = 0, prev_flit = 0;
    bit          exp_crd = 0;

    always #5 clk = ~clk;

    flit_link_port #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst(rst),
        .snd_valid(snd_valid), .snd_ready(snd_ready), .snd_data(snd_data),
        .snd_type(snd_type), .snd_last(snd_last),
        .lnk_o_flit(lnk_o_flit), .lnk_o_vld(lnk_o_vld), .lnk_o_end(lnk_o_end),
        .lnk_o_crd(lnk_o_crd),
        .lnk_i_flit(lnk_i_flit), .lnk_i_vld(lnk_i_vld), .lnk_i_end(lnk_i_end),
        .lnk_i_crd(lnk_i_crd),
        .rcv_valid(rcv_valid), .rcv_ready(rcv_ready), .rcv_data(rcv_data),
        .rcv_type(rcv_type), .rcv_end(rcv_end),
        .rcv_par_err(rcv_par_err), .rcv_sum_err(rcv_sum_err)
    );

    // loopback with optional single-flit corruption
    assign lnk_i_flit = lnk_o_flit ^ ((lnk_o_vld && link_cnt == corrupt_at) ? corrupt_val : 36'd0);
    assign lnk_i_vld  = lnk_o_vld;
    assign lnk_i_end  = lnk_o_end;
    assign lnk_i_crd  = lnk_o_crd;

    always @(posedge clk) begin
        if (rst) link_cnt <= 0;
        else if (lnk_o_vld) link_cnt <= link_cnt + 1;
    end

    always @(negedge clk) begin
        case (rx_mode)
            0:       rcv_ready = 1'b1;
            1:       rcv_ready = 1'b0;
            default: rcv_ready = ($urandom % 10) < 7;
        endcase
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic odd36(logic [35:0] v);
        return ^v;
    endfunction

    // monitor: sampled 1 time unit after the falling edge
    always @(negedge clk) begin
        #1;
        if (!rst) begin
            if (gap_pending) begin
                chk(!snd_ready, "R4", "ready low after last word", 64'(snd_ready), 64'd0);
                gap_pending = 0;
            end
            if (snd_valid && snd_ready) begin
                logic [2:0] k;
                k = in_pkt ? pkt_kind_b : snd_type;
                tx_q.push_back('{endf: 1'b0, kind: k, data: snd_data});
                tx_sum_b   = tx_sum_b ^ snd_data;
                pkt_kind_b = k;
                in_pkt     = 1;
                hs_cnt++;
                if (snd_last) begin
                    tx_q.push_back('{endf: 1'b1, kind: pkt_kind_b, data: tx_sum_b});
                    tx_sum_b    = '0;
                    in_pkt      = 0;
                    gap_pending = 1;
                end
            end
            // R7 R8: error pulses expected from the previous cycle's flit
            if (prev_flit || rcv_par_err || rcv_sum_err) begin
                chk(rcv_par_err == exp_par, "R7", "parity error pulse", 64'(rcv_par_err), 64'(exp_par));
                chk(rcv_sum_err == exp_sum, "R8", "checksum error pulse", 64'(rcv_sum_err), 64'(exp_sum));
            end
            if (rcv_par_err) par_seen++;
            if (rcv_sum_err) sum_seen++;
            exp_par = 0; exp_sum = 0; prev_flit = 0;
            if (lnk_o_vld) begin
                exp_t e;
                if (tx_q.size() == 0) begin
                    chk(0, "R10", "unexpected flit on link", 64'(lnk_o_flit), 64'd0);
                end else begin
                    e = tx_q.pop_front();
                    chk(lnk_o_flit[31:0] == e.data, "R4", "link data", 64'(lnk_o_flit[31:0]), 64'(e.data));
                    chk(lnk_o_flit[34:32] == e.kind, "R5", "link kind", 64'(lnk_o_flit[34:32]), 64'(e.kind));
                    chk(lnk_o_end == e.endf, "R4", "closing line", 64'(lnk_o_end), 64'(e.endf));
                    chk(!odd36(lnk_o_flit), "R1", "even parity", 64'(lnk_o_flit), 64'd0);
                end
                rx_q.push_back('{endf: lnk_i_end, kind: lnk_i_flit[34:32], data: lnk_i_flit[31:0]});
                prev_flit = 1;
                exp_par   = odd36(lnk_i_flit);
                exp_sum   = lnk_i_end && (lnk_i_flit[31:0] != rx_acc_b);
                rx_acc_b  = lnk_i_end ? 32'd0 : (rx_acc_b ^ lnk_i_flit[31:0]);
            end else if (lnk_o_end) begin
                chk(0, "R10", "end without valid", 64'(lnk_o_end), 64'd0);
            end
            // R6 credit pulse one cycle after read-out
            if (exp_crd || lnk_o_crd)
                chk(lnk_o_crd == exp_crd, "R6", "credit pulse", 64'(lnk_o_crd), 64'(exp_crd));
            exp_crd = 0;
            if (rcv_valid && rcv_ready) begin
                exp_t r;
                exp_crd = 1;
                if (rx_q.size() == 0) begin
                    chk(0, "R9", "read with nothing received", 64'(rcv_data), 64'd0);
                end else begin
                    r = rx_q.pop_front();
                    chk({rcv_end, rcv_type, rcv_data} == {r.endf, r.kind, r.data}, "R9", "delivered flit",
                        64'({rcv_end, rcv_type, rcv_data}), 64'({r.endf, r.kind, r.data}));
                end
            end
        end
    end

    task automatic send_pkt(input int len, input logic [2:0] kind, input bit gaps);
        for (int i = 0; i < len; i++) begin
            if (gaps && ($urandom % 3) == 0) begin
                snd_valid = 1'b0;
                @(negedge clk);
            end
            snd_valid = 1'b1;
            snd_data  = $urandom;
            snd_type  = (i == 0) ? kind : 3'($urandom);
            snd_last  = (i == len - 1);
            #1;
            while (!snd_ready) begin
                @(negedge clk);
                #1;
            end
            @(negedge clk);
        end
        snd_valid = 1'b0;
        snd_last  = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic stall_count(input string req, input int len);
        int base;
        base    = hs_cnt;
        rx_mode = 1;
        idle(1);
        fork
            send_pkt(len, 3'b010, 0);
            begin
                idle(30);
                #2;
                chk(hs_cnt - base == DEPTH, req, "words accepted into stalled receiver",
                    64'(hs_cnt - base), 64'(DEPTH));
                chk(!snd_ready, req, "ready low with no credit", 64'(snd_ready), 64'd0);
                rx_mode = 0;
            end
        join
        idle(20);
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        summary();
        $finish;
    end

    initial begin
        int seed_set;
        seed_set  = $urandom(32'd20240611);
        rst       = 1'b1;
        snd_valid = 1'b0;
        snd_last  = 1'b0;
        snd_data  = '0;
        snd_type  = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #2;
        // R2 reset state
        chk(snd_ready, "R2", "ready after reset", 64'(snd_ready), 64'd1);
        chk(!lnk_o_vld && !lnk_o_end, "R10", "link idle after reset", 64'({lnk_o_vld, lnk_o_end}), 64'd0);
        chk(!rcv_valid && !lnk_o_crd, "R6", "receiver empty after reset", 64'({rcv_valid, lnk_o_crd}), 64'd0);
        chk(!rcv_par_err && !rcv_sum_err, "R7", "no errors after reset", 64'({rcv_par_err, rcv_sum_err}), 64'd0);
        @(negedge clk);

        // R2: credit limit from reset
        stall_count("R2", 10);

        // R4: single-word packet, checksum equals the word
        rx_mode = 0;
        send_pkt(1, 3'b111, 0);
        idle(10);

        // R5: payload kinds are ignored
        send_pkt(5, 3'b110, 0);
        idle(10);

        // R7: parity bit flipped on a header
        begin
            int p0, s0;
            p0 = par_seen; s0 = sum_seen;
            corrupt_at  = link_cnt;
            corrupt_val = 36'h8_0000_0000;
            send_pkt(3, 3'b000, 0);
            idle(12);
            chk(par_seen - p0 == 1, "R7", "one parity error", 64'(par_seen - p0), 64'd1);
            chk(sum_seen == s0, "R8", "checksum unaffected by parity bit", 64'(sum_seen - s0), 64'd0);
        end

        // R8: data bit and parity flipped together in a payload flit
        begin
            int p0, s0;
            p0 = par_seen; s0 = sum_seen;
            corrupt_at  = link_cnt + 1;
            corrupt_val = 36'h8_0000_0001;
            send_pkt(4, 3'b001, 0);
            idle(12);
            chk(sum_seen - s0 == 1, "R8", "one checksum error", 64'(sum_seen - s0), 64'd1);
            chk(par_seen == p0, "R7", "parity kept even", 64'(par_seen - p0), 64'd0);
        end

        // R7 R8: closing flit data bit flipped, both pulses at once
        begin
            int p0, s0;
            p0 = par_seen; s0 = sum_seen;
            corrupt_at  = link_cnt + 2;
            corrupt_val = 36'h0_0001_0000;
            send_pkt(2, 3'b011, 0);
            idle(12);
            chk(par_seen - p0 == 1, "R7", "closing flit parity error", 64'(par_seen - p0), 64'd1);
            chk(sum_seen - s0 == 1, "R8", "closing flit checksum error", 64'(sum_seen - s0), 64'd1);
            corrupt_at = 32'hFFFF_FFFF;
        end

        // streaming with reader always ready: send and credit on the same edge
        for (int n = 0; n < 12; n++) send_pkt(1 + ($urandom % 6), 3'($urandom), 0);
        idle(20);
        stall_count("R3", 8);

        // constrained random traffic with random reader and occasional corruption
        rx_mode = 2;
        for (int n = 0; n < 60; n++) begin
            if (n % 9 == 4) begin
                corrupt_at  = link_cnt + ($urandom % 3);
                corrupt_val = 36'(1) << ($urandom % 36);
            end
            send_pkt(1 + ($urandom % 7), 3'($urandom), 1);
        end
        rx_mode = 0;
        idle(40);
        corrupt_at = 32'hFFFF_FFFF;
        // R3 credits intact after random traffic
        stall_count("R3", 9);
        idle(20);

        chk(tx_q.size() == 0, "R4", "all sent flits seen on link", 64'(tx_q.size()), 64'd0);
        chk(rx_q.size() == 0, "R9", "all received flits delivered", 64'(rx_q.size()), 64'd0);
        summary();
        $finish;
    end

endmodule